// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is the purely combinational arithmetic and logic unit of a small RISC execute stage. It receives two operands that are already 32 bits wide, because any immediate has been sign- or zero-extended before it arrives. It also receives a 4-bit operation select. In the same cycle it returns a 32-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag.

Addition and subtraction share one adder. Subtraction adds the bitwise inverse of the second operand with a carry-in of one. The two less-than operations reuse that adder. The signed form takes the sum sign corrected by the overflow term. The unsigned form takes the borrow, which is the inverse of the carry out. Because the block holds no state, the state-machine layout of the house style reduces to the single operation-select decode in the top module.

Top module: `alu32_core`

## Requirements
- R1: Select 4'h0 (signed add) drives result = (A + B) mod 2^32.
- R2: Select 4'h1 (unsigned add) drives the same modular sum as R1.
- R3: Select 4'h2 (signed subtract) and 4'h3 (unsigned subtract) drive result = (A - B) mod 2^32.
- R4: Selects 4'h4, 4'h5, 4'h6 and 4'h7 drive bitwise A AND B, A OR B, A XOR B and NOT(A OR B) respectively.
- R5: For selects 4'h0 and 4'h2, the overflow output is high exactly when the true signed sum or difference falls outside the 32-bit two's-complement range.
- R6: For every select other than 4'h0 and 4'h2, the overflow output is low.
- R7: Select 4'hA drives 32'd1 when A < B as two's-complement numbers, and 32'd0 otherwise.
- R8: Select 4'hB drives 32'd1 when A < B as unsigned numbers, and 32'd0 otherwise.
- R9: The zero output is high exactly when all 32 result bits are 0, for every select.
- R10: Unused selects 4'h8, 4'h9 and 4'hC to 4'hF drive a result of 0 and a low overflow output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation select code |
| result | output | 32 | Operation result |
| zero_o | output | 1 | High when result is all zeros |
| ovf_o | output | 1 | Signed overflow for signed add and subtract |

## Verification
The bench first applies directed patterns, then random operand pairs across all sixteen select codes. Sums that cross the signed boundary in each direction show the overflow rule apart from a plain carry-out. Equal operands and the pair 0x80000000 against 1 separate the signed less-than from the unsigned less-than and from a strict less-or-equal test. Subtracting equal values, and AND with disjoint masks, yield a zero result, which exercises the zero flag. The unused codes are applied with operands that would overflow, so a wrong result or a set overflow flag on those codes shows up at the ports.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bw_fn_e;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             sovf_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_eff     = sub_en ? ~b_in : b_in;
        wide_sum  = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_en};
        sum_out   = wide_sum[MSB:0];
        carry_out = wide_sum[WIDTH];
        sovf_out  = (a_in[MSB] == b_eff[MSB]) && (sum_out[MSB] != a_in[MSB]);
    end

    // R5: adding operands of opposite sign can never overflow
    always_comb begin
        if (!sub_en && (a_in[MSB] != b_in[MSB]))
            a_r5_mixed_sign_add: assert (!sovf_out)
                else $error("a_r5_mixed_sign_add");
    end
endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       fn_sel,
    output logic [WIDTH-1:0] y_out
);
    import alu32_pkg::*;

    bw_fn_e fn;
    assign fn = bw_fn_e'(fn_sel);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (fn)
                BW_AND:  y_out[i] = a_in[i] & b_in[i];
                BW_OR:   y_out[i] = a_in[i] | b_in[i];
                BW_XOR:  y_out[i] = a_in[i] ^ b_in[i];
                BW_NOR:  y_out[i] = ~(a_in[i] | b_in[i]);
                default: y_out[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu32_compare.sv
module alu32_compare (
    input  logic sum_msb,
    input  logic sovf,
    input  logic carry,
    input  logic unsigned_cmp,
    output logic less
);
    always_comb begin
        if (unsigned_cmp)
            less = ~carry;
        else
            less = sum_msb ^ sovf;
    end
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_o,
    output logic             ovf_o
);
    import alu32_pkg::*;

    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic             sub_en;
    logic [WIDTH-1:0] sum_w;
    logic             carry_w;
    logic             sovf_w;
    logic [WIDTH-1:0] bw_w;
    logic             less_w;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        sub_en = (op == OP_SUB) || (op == OP_SUBU) ||
                 (op == OP_SLT) || (op == OP_SLTU);
    end

    alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .sub_en    (sub_en),
        .sum_out   (sum_w),
        .carry_out (carry_w),
        .sovf_out  (sovf_w)
    );

    alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_in   (opnd_a),
        .b_in   (opnd_b),
        .fn_sel (op_sel[1:0]),
        .y_out  (bw_w)
    );

    alu32_compare u_compare (
        .sum_msb      (sum_w[MSB]),
        .sovf         (sovf_w),
        .carry        (carry_w),
        .unsigned_cmp (op_sel[0]),
        .less         (less_w)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin
                result = sum_w;
                ovf_o  = sovf_w;
            end
            OP_ADDU, OP_SUBU: begin
                result = sum_w;
                ovf_o  = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOR: begin
                result = bw_w;
                ovf_o  = 1'b0;
            end
            OP_SLT, OP_SLTU: begin
                result = {{(WIDTH-1){1'b0}}, less_w};
                ovf_o  = 1'b0;
            end
            default: begin
                result = '0;
                ovf_o  = 1'b0;
            end
        endcase
    end

    assign zero_o = ~|result;

    // R9: subtracting equal operands gives a zero flag
    always_comb begin
        if ((op_sel == 4'h2 || op_sel == 4'h3) && opnd_a == opnd_b)
            a_r9_sub_equal_zero: assert (zero_o)
                else $error("a_r9_sub_equal_zero");
    end

    // R6: unsigned add and subtract never raise overflow
    always_comb begin
        if (op_sel == 4'h1 || op_sel == 4'h3)
            a_r6_no_overflow: assert (!ovf_o)
                else $error("a_r6_no_overflow");
    end

    // R7 / R8: compare results are 0 or 1 only
    always_comb begin
        if (op_sel == 4'hA || op_sel == 4'hB)
            a_r7_r8_bool_result: assert (result[MSB:1] == '0)
                else $error("a_r7_r8_bool_result");
    end

    // R10: unused codes give zero result and no overflow
    always_comb begin
        if (op_sel == 4'h8 || op_sel == 4'h9 || op_sel >= 4'hC)
            a_r10_unused_quiet: assert (zero_o && !ovf_o)
                else $error("a_r10_unused_quiet");
    end
endmodule

// File: tb/alu32_core_test.sv
module alu32_core_test;
    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [3:0]  op_sel;
    logic        zero_o, ovf_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu32_core uut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .op_sel (op_sel),
        .result (result),
        .zero_o (zero_o),
        .ovf_o  (ovf_o)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2, 4'h3: return "R3";
            4'h4, 4'h5, 4'h6, 4'h7: return "R4";
            4'hA: return "R7";
            4'hB: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] exp_result(input logic [3:0] op,
                                               input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'h0, 4'h1: return a + b;
            4'h2, 4'h3: return a - b;
            4'h4: return a & b;
            4'h5: return a | b;
            4'h6: return a ^ b;
            4'h7: return ~(a | b);
            4'hA: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'hB: return (a < b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [3:0] op,
                                     input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        if (op == 4'h0) t = sa + sb;
        else if (op == 4'h2) t = sa - sb;
        else return 1'b0;
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic        ev;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        #2;
        er = exp_result(op, a, b);
        ev = exp_ovf(op, a, b);
        n_checks++;
        if (result !== er) begin
            n_errors++;
            $display("FAIL %s result op=%h a=%h b=%h actual=%h expected=%h",
                     tag_of(op), op, a, b, result, er);
        end
        n_checks++;
        if (zero_o !== (er == 32'd0)) begin
            n_errors++;
            $display("FAIL R9 zero op=%h actual=%b expected=%b", op, zero_o, (er == 32'd0));
        end
        n_checks++;
        if (ovf_o !== ev) begin
            n_errors++;
            $display("FAIL %s overflow op=%h a=%h b=%h actual=%b expected=%b",
                     (op == 4'h0 || op == 4'h2) ? "R5" : "R6", op, a, b, ovf_o, ev);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        opnd_a = '0; opnd_b = '0; op_sel = '0;
        seed_dummy = $urandom(32'h5eed_1234);
        // initial state: add of zeros gives zero result, zero flag high (R1, R9)
        apply(4'h0, 32'h0, 32'h0);
        // R5 overflow corners
        apply(4'h0, 32'h7fffffff, 32'h1);
        apply(4'h0, 32'h80000000, 32'hffffffff);
        apply(4'h2, 32'h80000000, 32'h1);
        apply(4'h2, 32'h7fffffff, 32'hffffffff);
        apply(4'h0, 32'h7fffffff, 32'h80000000);
        // R6 unsigned variants with the same operands
        apply(4'h1, 32'h7fffffff, 32'h1);
        apply(4'h3, 32'h80000000, 32'h1);
        apply(4'h1, 32'hffffffff, 32'h1);
        // R3 equal operands -> zero (R9)
        apply(4'h2, 32'h1234abcd, 32'h1234abcd);
        apply(4'h3, 32'h0, 32'h1);
        // R4 logic patterns
        apply(4'h4, 32'hf0f0f0f0, 32'h0f0f0f0f);
        apply(4'h5, 32'hf0f0f0f0, 32'h0f0f0f0f);
        apply(4'h6, 32'hdeadbeef, 32'hdeadbeef);
        apply(4'h7, 32'h0, 32'h0);
        apply(4'h7, 32'hf0f0f0f0, 32'h0f0f0f0f);
        // R7 / R8 signedness and equality corners
        apply(4'hA, 32'h80000000, 32'h1);
        apply(4'hB, 32'h80000000, 32'h1);
        apply(4'hA, 32'h5, 32'h5);
        apply(4'hB, 32'h5, 32'h5);
        apply(4'hA, 32'h7fffffff, 32'h80000000);
        apply(4'hB, 32'h1, 32'hffffffff);
        apply(4'hA, 32'hfffffffe, 32'hffffffff);
        // R10 unused codes with overflowing operands
        for (int op = 8; op < 16; op++)
            if (op != 10 && op != 11)
                apply(op[3:0], 32'h7fffffff, 32'h1);
        // random sweep over all codes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) ra = {ra[31], 31'h7fffffff};
            apply(4'($urandom_range(15, 0)), ra, rb);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule